// File: doc/BRIEF.md
# Dual-Channel Disk Register Address Decoder

This block sits between a host's programmed-I/O port and the register files of a two-channel disk host controller. Each access is compared against five relocatable address windows: a command window and a control window for each of the two channels, and one bus-master window. The block reports which window was hit, which channel it belongs to, and the offset inside it. Window bases are loaded by 32-bit configuration writes. An I/O-enable flag and a bus-master-enable flag are taken from the configuration command register.

Accesses that land in a command or control window are forwarded to one of four drive slots. The slot is picked from the channel and a per-channel device bit. That bit is latched whenever the host writes the channel's drive-select register. The 16-bit data port turns a 32-bit host access into two 16-bit drive transfers, low half first. Illegal sizes and unmapped addresses are reported with an error flag and never stop the block. Hits in the bus-master window are only decoded here, because that register file sits in a neighbouring block.

One access is in flight at a time. The host sees `req_ready` high only when the block is idle, and it gets exactly one `rsp_valid` pulse per accepted request.

Top module: `hdc_pio_decoder`

## Requirements
- R1: Windows are primary command (span 8), primary control (span 4), secondary command (span 8), secondary control (span 4) and bus-master (span 16). An address hits a window when base <= addr < base + span. The reported offset is addr - base. Block codes are 1 = command, 2 = control, 3 = bus-master and 0 = no hit. The channel is 0 for primary and 1 for secondary.
- R2: Windows may overlap. The first match wins, in this order: primary command, primary control, secondary command, secondary control, bus-master. All five bases reset to 0.
- R3: A bus-master hit belongs to channel 0 when its offset is below 8, and to channel 1 otherwise. It causes no drive transfer and returns zero data with no error.
- R4: A configuration write to address 0x10 + 4*k (k = 0..4, in the window order of R2) loads base k from the low address bits of the data. The write is ignored when the whole 32-bit data value is zero.
- R5: A configuration write to address 0x04 sets the I/O-enable flag from data bit 0 and the bus-master-enable flag from bit 2. Both flags reset to 0.
- R6: A byte write to offset 6 of a command window, with I/O enabled, latches data bit 4 as that channel's device bit. The same write is still forwarded to the drive, already using the new selection.
- R7: The drive index is 2 * channel + device bit. Both device bits reset to 0.
- R8: While I/O is disabled, an access that hits a window returns error 0 and data 0. It makes no drive transfer and does not change the device bit.
- R9: Offset 0 of a command window is the data port. A 16-bit access makes one drive transfer. A 32-bit access makes two, low half first, and a read returns {second, first}.
- R10: Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = illegal. With I/O enabled, the following give error 1, data 0 and no drive transfer: size 3, a byte access to the data port, and a non-byte access to any other command or control register.
- R11: An address that matches no window gives error 1, block code 0 and data 0, whether or not I/O is enabled.
- R12: Drive slots are marked present by `drv_present[index]`. A read from an absent slot returns 0, a write to one is dropped, and neither is flagged as an error.
- R13: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` pulses for one cycle, one edge after the last drive transfer: 2 edges after acceptance, or 3 for a split data access. Byte reads return the low drive byte zero-extended, and 16-bit reads return the drive word zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe (32-bit write) |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| drv_present | input | 4 | One bit per drive slot, set when a drive is attached |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Host I/O address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Host write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmapped address or illegal size |
| rsp_blk | output | 2 | Decoded block code |
| rsp_chan | output | 1 | Decoded channel |
| rsp_offset | output | 4 | Offset within the window |
| drv_valid | output | 1 | Drive transfer strobe |
| drv_write | output | 1 | Drive transfer direction |
| drv_index | output | 2 | Target drive slot |
| drv_blk | output | 2 | Block code of the drive register |
| drv_offset | output | 4 | Drive register offset |
| drv_wdata | output | 16 | Drive write data |
| drv_rdata | input | 16 | Drive read data, sampled at the edge that ends a transfer |
| io_en | output | 1 | I/O-enable flag |
| bm_en | output | 1 | Bus-master-enable flag |

## Verification
The embedded properties check several rules on every cycle:
- drive transfers only target present slots;
- the two halves of a split access go to the same slot in adjacent cycles;
- non-data registers only see byte transfers;
- erroring accesses never reach a drive;
- a base never moves to zero;
- a device bit only changes after a select write.

Other behaviour can only be shown by the scenarios, because it depends on the value the bench predicts:
- window priority under overlap;
- the bus-master channel split;
- the effect of disabled decode;
- the exact assembly of split read data;
- the response latency.

// File: rtl/hdc_pio_pkg.sv
package hdc_pio_pkg;

    localparam int NUM_WIN    = 5;
    localparam int NUM_CHAN   = 2;
    localparam int CHAN_W     = $clog2(NUM_CHAN);
    localparam int NUM_DRV    = 2 * NUM_CHAN;
    localparam int DRV_W      = $clog2(NUM_DRV);
    localparam int CMD_SPAN   = 8;
    localparam int CTRL_SPAN  = 4;
    localparam int BM_SPAN    = 16;
    localparam int OFS_W      = $clog2(BM_SPAN);
    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int BYTE_W     = 8;
    localparam int SEL_BIT    = 4;
    localparam int IOEN_BIT   = 0;
    localparam int BMEN_BIT   = 2;
    localparam int CFG_CMD_ADDR  = 'h04;
    localparam int CFG_BAR0_ADDR = 'h10;

    localparam logic [OFS_W-1:0] DATA_OFS   = OFS_W'(0);
    localparam logic [OFS_W-1:0] SEL_OFS    = OFS_W'(6);
    localparam logic [OFS_W-1:0] BM_SEC_OFS = OFS_W'(8);

    // window index order is the match priority
    localparam int WIN_PCMD = 0;
    localparam int WIN_PCTL = 1;
    localparam int WIN_SCMD = 2;
    localparam int WIN_SCTL = 3;
    localparam int WIN_BM   = 4;

    typedef enum logic [1:0] {
        BLK_NONE = 2'd0,
        BLK_CMD  = 2'd1,
        BLK_CTRL = 2'd2,
        BLK_BM   = 2'd3
    } blk_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } xfer_st_e;

    typedef struct packed {
        logic              hit;
        blk_e              blk;
        logic [CHAN_W-1:0] chan;
        logic [OFS_W-1:0]  ofs;
    } dec_t;

    typedef struct packed {
        dec_t              dec;
        logic              write;
        size_e             size;
        logic [WORD_W-1:0] wdata;
        logic              drv;
        logic              split;
        logic              err;
        logic [DRV_W-1:0]  idx;
    } stage_t;

    function automatic int win_span(input int w);
        if (w == WIN_BM)
            return BM_SPAN;
        else if (w == WIN_PCTL || w == WIN_SCTL)
            return CTRL_SPAN;
        else
            return CMD_SPAN;
    endfunction

    function automatic blk_e win_blk(input int w);
        if (w == WIN_BM)
            return BLK_BM;
        else if (w == WIN_PCTL || w == WIN_SCTL)
            return BLK_CTRL;
        else
            return BLK_CMD;
    endfunction

    function automatic logic [CHAN_W-1:0] win_chan(input int w);
        return (w == WIN_SCMD || w == WIN_SCTL) ? CHAN_W'(1) : CHAN_W'(0);
    endfunction

endpackage

// File: rtl/hdc_win_match.sv
module hdc_win_match
    import hdc_pio_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]              addr,
    input  logic [NUM_WIN-1:0][AW-1:0] base,
    output dec_t                       dec
);

    logic [NUM_WIN-1:0]            hit_w;
    logic [NUM_WIN-1:0][OFS_W-1:0] ofs_w;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int SPAN = win_span(w);
        logic [AW:0] lo_ext;
        logic [AW:0] hi_ext;
        logic [AW:0] a_ext;
        assign lo_ext   = {1'b0, base[w]};
        assign hi_ext   = lo_ext + (AW+1)'(SPAN);
        assign a_ext    = {1'b0, addr};
        assign hit_w[w] = (a_ext >= lo_ext) && (a_ext < hi_ext);
        // a hit bounds the distance below the span, so the low bits suffice
        assign ofs_w[w] = addr[OFS_W-1:0] - base[w][OFS_W-1:0];
    end

    always_comb begin
        dec = '0;
        // walk from lowest priority upward so the first window wins
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_w[w]) begin
                dec.hit = 1'b1;
                dec.blk = win_blk(w);
                dec.ofs = ofs_w[w];
                if (w == WIN_BM)
                    dec.chan = (ofs_w[w] >= BM_SEC_OFS) ? CHAN_W'(1) : CHAN_W'(0);
                else
                    dec.chan = win_chan(w);
            end
        end
    end

endmodule

// File: rtl/hdc_cfg_regs.sv
module hdc_cfg_regs
    import hdc_pio_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_wr,
    input  logic [7:0]                 cfg_addr,
    input  logic [WORD_W-1:0]          cfg_wdata,
    output logic [NUM_WIN-1:0][AW-1:0] base,
    output logic                       io_en,
    output logic                       bm_en
);

    logic cmd_hit;
    assign cmd_hit = cfg_wr && (cfg_addr == 8'(CFG_CMD_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            io_en <= 1'b0;
            bm_en <= 1'b0;
        end else if (cmd_hit) begin
            io_en <= cfg_wdata[IOEN_BIT];
            bm_en <= cfg_wdata[BMEN_BIT];
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_bar
        localparam logic [7:0] BAR_ADDR = 8'(CFG_BAR0_ADDR + 4 * w);
        logic load;
        assign load = cfg_wr && (cfg_addr == BAR_ADDR) && (cfg_wdata != '0);

        always_ff @(posedge clk) begin
            if (rst)
                base[w] <= '0;
            else if (load)
                base[w] <= cfg_wdata[AW-1:0];
        end

        AST_BAR_NONZERO: assert property (@(posedge clk) disable iff (rst)
            !$stable(base[w]) |-> (base[w] != '0)); // R4
    end

endmodule

// File: rtl/hdc_dev_sel.sv
module hdc_dev_sel
    import hdc_pio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_wr,
    input  logic [CHAN_W-1:0]   sel_chan,
    input  logic                sel_bit,
    output logic [NUM_CHAN-1:0] dev_q
);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst)
                dev_q[c] <= 1'b0;
            else if (sel_wr && (sel_chan == CHAN_W'(c)))
                dev_q[c] <= sel_bit;
        end

        AST_DEV_HOLD: assert property (@(posedge clk) disable iff (rst)
            !$stable(dev_q[c]) |-> ($past(sel_wr) && ($past(sel_chan) == CHAN_W'(c)))); // R6
    end

endmodule

// File: rtl/hdc_pio_decoder.sv
module hdc_pio_decoder
    import hdc_pio_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [7:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic [3:0]          drv_present,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [1:0]          req_size,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                rsp_err,
    output logic [1:0]          rsp_blk,
    output logic                rsp_chan,
    output logic [3:0]          rsp_offset,
    output logic                drv_valid,
    output logic                drv_write,
    output logic [1:0]          drv_index,
    output logic [1:0]          drv_blk,
    output logic [3:0]          drv_offset,
    output logic [15:0]         drv_wdata,
    input  logic [15:0]         drv_rdata,
    output logic                io_en,
    output logic                bm_en
);

    logic [NUM_WIN-1:0][AW-1:0] base;
    logic [NUM_CHAN-1:0]        dev_q;
    dec_t                       dec;

    hdc_cfg_regs #(.AW(AW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .base     (base),
        .io_en    (io_en),
        .bm_en    (bm_en)
    );

    hdc_win_match #(.AW(AW)) u_match (
        .addr(req_addr),
        .base(base),
        .dec (dec)
    );

    // ---------------- request classification ----------------
    size_e             sz;
    logic              is_data;
    logic              is_reg;
    logic              size_bad;
    logic              acc_err;
    logic              live;
    logic              accept;
    logic              sel_wr;
    logic              dev_now;
    logic [DRV_W-1:0]  idx;
    logic              needs_drv;
    xfer_st_e          state;

    assign sz       = size_e'(req_size);
    assign is_data  = (dec.blk == BLK_CMD) && (dec.ofs == DATA_OFS);
    assign is_reg   = ((dec.blk == BLK_CMD) || (dec.blk == BLK_CTRL)) && !is_data;
    assign size_bad = (sz == SZ_BAD) || (is_data && (sz == SZ_BYTE)) ||
                      (is_reg && (sz != SZ_BYTE));
    assign acc_err  = !dec.hit || (io_en && size_bad);
    assign live     = io_en && dec.hit && !size_bad;
    assign req_ready = (state == ST_IDLE);
    assign accept   = req_valid && req_ready;
    assign sel_wr   = accept && live && req_write &&
                      (dec.blk == BLK_CMD) && (dec.ofs == SEL_OFS);
    // a select write already steers its own forwarded transfer
    assign dev_now  = sel_wr ? req_wdata[SEL_BIT] : dev_q[dec.chan];
    assign idx      = {dec.chan, dev_now};
    assign needs_drv = live && ((dec.blk == BLK_CMD) || (dec.blk == BLK_CTRL)) &&
                       drv_present[idx];

    hdc_dev_sel u_dev (
        .clk     (clk),
        .rst     (rst),
        .sel_wr  (sel_wr),
        .sel_chan(dec.chan),
        .sel_bit (req_wdata[SEL_BIT]),
        .dev_q   (dev_q)
    );

    // ---------------- transfer sequencer ----------------
    stage_t              stg;
    logic [HALF_W-1:0]   lo_q;
    logic [WORD_W-1:0]   rd_value;
    logic                rsp_valid_q;
    logic [WORD_W-1:0]   rsp_rdata_q;
    logic                rsp_err_q;
    dec_t                rsp_dec_q;
    logic                finish;

    always_comb begin
        rd_value = '0;
        if (stg.drv && !stg.write) begin
            if (state == ST_HI)
                rd_value = {drv_rdata, lo_q};
            else if (stg.size == SZ_BYTE)
                rd_value = {{(WORD_W-BYTE_W){1'b0}}, drv_rdata[BYTE_W-1:0]};
            else
                rd_value = {{(WORD_W-HALF_W){1'b0}}, drv_rdata};
        end
    end

    assign finish = (state == ST_HI) || ((state == ST_LO) && !(stg.drv && stg.split));

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            stg         <= '0;
            lo_q        <= '0;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            rsp_err_q   <= 1'b0;
            rsp_dec_q   <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        stg.dec   <= dec;
                        stg.write <= req_write;
                        stg.size  <= sz;
                        stg.wdata <= req_wdata;
                        stg.drv   <= needs_drv;
                        stg.split <= is_data && (sz == SZ_WORD);
                        stg.err   <= acc_err;
                        stg.idx   <= idx;
                        state     <= ST_LO;
                    end
                end
                ST_LO: begin
                    if (stg.drv && stg.split) begin
                        lo_q  <= drv_rdata;
                        state <= ST_HI;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_HI: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (finish) begin
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= rd_value;
                rsp_err_q   <= stg.err;
                rsp_dec_q   <= stg.dec;
            end
        end
    end

    assign drv_valid  = ((state == ST_LO) || (state == ST_HI)) && stg.drv;
    assign drv_write  = stg.write;
    assign drv_index  = stg.idx;
    assign drv_blk    = stg.dec.blk;
    assign drv_offset = stg.dec.ofs;
    assign drv_wdata  = (state == ST_HI) ? stg.wdata[WORD_W-1:HALF_W] : stg.wdata[HALF_W-1:0];

    assign rsp_valid  = rsp_valid_q;
    assign rsp_rdata  = rsp_rdata_q;
    assign rsp_err    = rsp_err_q;
    assign rsp_blk    = rsp_dec_q.hit ? rsp_dec_q.blk : BLK_NONE;
    assign rsp_chan   = rsp_dec_q.chan;
    assign rsp_offset = rsp_dec_q.ofs;

    // ---------------- properties ----------------
    AST_DRV_POPULATED: assert property (@(posedge clk) disable iff (rst)
        drv_valid |-> drv_present[drv_index]); // R12

    AST_SPLIT_LO_FIRST: assert property (@(posedge clk) disable iff (rst)
        (drv_valid && (state == ST_HI)) |-> ($past(drv_valid) && $stable(drv_index))); // R9

    AST_BYTE_REGS: assert property (@(posedge clk) disable iff (rst)
        (drv_valid && !((drv_blk == BLK_CMD) && (drv_offset == DATA_OFS))) |->
            (stg.size == SZ_BYTE)); // R10

    AST_ERR_NO_DRV: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> !$past(drv_valid)); // R10

    AST_MISS_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_blk == BLK_NONE)) |-> rsp_err); // R11

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R13

endmodule

// File: tb/hdc_pio_decoder_tb_top.sv
module hdc_pio_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  drv_present = 4'b0111;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [1:0]  rsp_blk;
    logic        rsp_chan;
    logic [3:0]  rsp_offset;
    logic        drv_valid;
    logic        drv_write;
    logic [1:0]  drv_index;
    logic [1:0]  drv_blk;
    logic [3:0]  drv_offset;
    logic [15:0] drv_wdata;
    logic [15:0] drv_rdata;
    logic        io_en;
    logic        bm_en;

    always #5 clk = ~clk;

    hdc_pio_decoder #(.AW(16)) dut_i (.*);

    // drive model: read data carries a running count of drive reads
    logic [7:0] model_cnt = '0;
    assign drv_rdata = {model_cnt, 2'b00, drv_index, drv_offset};

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        logic [1:0]  blk;
        logic        chan;
        logic [3:0]  ofs;
        int          cyc;
        string       tag;
    } rsp_item_t;

    typedef struct {
        logic        write;
        logic [1:0]  idx;
        logic [1:0]  blk;
        logic [3:0]  ofs;
        logic [15:0] wdata;
        string       tag;
    } drv_item_t;

    rsp_item_t rsp_q[$];
    drv_item_t drv_q[$];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model state ----------------
    logic [15:0] m_base [5] = '{default: 16'h0};
    logic        m_io = 1'b0;
    logic        m_dev [2] = '{default: 1'b0};
    logic [7:0]  pred_cnt = '0;

    function automatic void mdecode(input logic [15:0] a, output logic hit,
                                    output logic [1:0] blk, output logic ch,
                                    output logic [3:0] ofs);
        int sp [5] = '{8, 4, 8, 4, 16};
        hit = 1'b0; blk = 2'd0; ch = 1'b0; ofs = 4'd0;
        for (int w = 4; w >= 0; w--) begin
            if (({1'b0, a} >= {1'b0, m_base[w]}) &&
                ({1'b0, a} < ({1'b0, m_base[w]} + 17'(sp[w])))) begin
                hit = 1'b1;
                ofs = 4'(a - m_base[w]);
                blk = (w == 4) ? 2'd3 : ((w % 2 == 0) ? 2'd1 : 2'd2);
                ch  = (w == 4) ? (ofs >= 4'd8) : (w >= 2);
            end
        end
    endfunction

    task automatic cfg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == 8'h04) m_io = d[0];
        for (int k = 0; k < 5; k++)
            if (a == 8'(8'h10 + 4 * k) && d != 32'h0) m_base[k] = d[15:0];
    endtask

    // driver: predicts the outcome, queues it, then issues the request
    task automatic access(input string tag, input logic wr, input logic [15:0] a,
                          input logic [1:0] size, input logic [31:0] wd);
        logic hit, ch, dat, rg, bad, err, live, drv, split;
        logic [1:0] blk, idx;
        logic [3:0] ofs;
        logic [15:0] v1, v2;
        rsp_item_t r;
        drv_item_t d;
        mdecode(a, hit, blk, ch, ofs);
        dat   = (blk == 2'd1) && (ofs == 4'd0);
        rg    = ((blk == 2'd1) || (blk == 2'd2)) && !dat;
        bad   = (size == 2'd3) || (dat && size == 2'd0) || (rg && size != 2'd0);
        err   = !hit || (m_io && bad);
        live  = m_io && hit && !bad;
        if (live && wr && blk == 2'd1 && ofs == 4'd6) m_dev[ch] = wd[4];
        idx   = {ch, m_dev[ch]};
        drv   = live && (blk == 2'd1 || blk == 2'd2) && drv_present[idx];
        split = dat && (size == 2'd2);
        r.rdata = 32'h0;
        if (drv) begin
            d.write = wr; d.idx = idx; d.blk = blk; d.ofs = ofs;
            d.wdata = wd[15:0]; d.tag = tag;
            drv_q.push_back(d);
            if (split) begin
                d.wdata = wd[31:16];
                drv_q.push_back(d);
            end
            if (!wr) begin
                pred_cnt++;
                v1 = {pred_cnt, 2'b00, idx, ofs};
                if (split) begin
                    pred_cnt++;
                    v2 = {pred_cnt, 2'b00, idx, ofs};
                    r.rdata = {v2, v1};
                end else if (size == 2'd0) begin
                    r.rdata = {24'h0, v1[7:0]};
                end else begin
                    r.rdata = {16'h0, v1};
                end
            end
        end
        r.err = err; r.blk = hit ? blk : 2'd0; r.chan = ch; r.ofs = ofs; r.tag = tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r.cyc = cyc + 2 + ((drv && split) ? 1 : 0);
        rsp_q.push_back(r);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = size; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compares what the design produces against the queues
    always @(negedge clk) begin
        if (!rst) begin
            if (drv_valid) begin
                if (drv_q.size() == 0) begin
                    chk("R12", "unexpected drive transfer", 32'h1, 32'h0);
                end else begin
                    drv_item_t e;
                    e = drv_q.pop_front();
                    chk(e.tag, "drive write", 32'(drv_write), 32'(e.write));
                    chk(e.tag, "drive index (R7)", 32'(drv_index), 32'(e.idx));
                    chk(e.tag, "drive block", 32'(drv_blk), 32'(e.blk));
                    chk(e.tag, "drive offset", 32'(drv_offset), 32'(e.ofs));
                    if (e.write) chk(e.tag, "drive wdata", 32'(drv_wdata), 32'(e.wdata));
                end
                if (!drv_write) model_cnt <= model_cnt + 8'd1;
            end
            if (rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    chk("R13", "unexpected response", 32'h1, 32'h0);
                end else begin
                    rsp_item_t e;
                    e = rsp_q.pop_front();
                    chk(e.tag, "rdata", rsp_rdata, e.rdata);
                    chk(e.tag, "err", 32'(rsp_err), 32'(e.err));
                    chk(e.tag, "block", 32'(rsp_blk), 32'(e.blk));
                    chk(e.tag, "channel", 32'(rsp_chan), 32'(e.chan));
                    chk(e.tag, "offset", 32'(rsp_offset), 32'(e.ofs));
                    chk(e.tag, "latency (R13)", 32'(cyc), 32'(e.cyc));
                end
            end
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R5", "reset req_ready", 32'(req_ready), 32'h1);
        chk("R5", "reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R5", "reset drv_valid", 32'(drv_valid), 32'h0);
        chk("R5", "reset io_en", 32'(io_en), 32'h0);
        chk("R5", "reset bm_en", 32'(bm_en), 32'h0);

        // disabled decode, all bases at zero: overlap priority
        access("R2", 1'b0, 16'h0003, 2'd0, 32'h0);
        access("R3", 1'b0, 16'h000A, 2'd1, 32'h0);
        access("R8", 1'b1, 16'h0006, 2'd0, 32'h10);
        access("R11", 1'b0, 16'h0020, 2'd0, 32'h0);

        cfg(8'h04, 32'h5);
        chk("R5", "io_en", 32'(io_en), 32'h1);
        chk("R5", "bm_en", 32'(bm_en), 32'h1);
        cfg(8'h10, 32'h01F0);
        cfg(8'h14, 32'h03F4);
        cfg(8'h18, 32'h0170);
        cfg(8'h1C, 32'h0374);
        cfg(8'h20, 32'hC000);
        cfg(8'h10, 32'h0);

        access("R4", 1'b0, 16'h01F7, 2'd0, 32'h0);
        access("R6", 1'b1, 16'h01F6, 2'd0, 32'h10);
        access("R7", 1'b0, 16'h01F7, 2'd0, 32'h0);
        access("R9", 1'b0, 16'h01F0, 2'd1, 32'h0);
        access("R9", 1'b0, 16'h01F0, 2'd2, 32'h0);
        access("R9", 1'b1, 16'h01F0, 2'd2, 32'hDEADBEEF);
        access("R1", 1'b0, 16'h03F6, 2'd0, 32'h0);
        access("R7", 1'b0, 16'h0177, 2'd0, 32'h0);
        access("R12", 1'b1, 16'h0176, 2'd0, 32'h10);
        access("R12", 1'b0, 16'h0177, 2'd0, 32'h0);
        access("R12", 1'b1, 16'h0171, 2'd0, 32'h5A);
        access("R1", 1'b0, 16'h0376, 2'd0, 32'h0);
        access("R3", 1'b0, 16'hC002, 2'd0, 32'h0);
        access("R3", 1'b0, 16'hC00A, 2'd2, 32'h0);
        access("R10", 1'b0, 16'h01F0, 2'd0, 32'h0);
        access("R10", 1'b0, 16'h01F7, 2'd1, 32'h0);
        access("R10", 1'b1, 16'h03F6, 2'd2, 32'h0);
        access("R10", 1'b0, 16'h01F2, 2'd3, 32'h0);
        access("R11", 1'b0, 16'h0100, 2'd0, 32'h0);

        cfg(8'h1C, 32'h01F2);
        access("R2", 1'b0, 16'h01F3, 2'd0, 32'h0);
        access("R6", 1'b1, 16'h01F6, 2'd0, 32'h0);
        access("R7", 1'b0, 16'h01F4, 2'd0, 32'h0);

        cfg(8'h04, 32'h0);
        access("R8", 1'b0, 16'h01F7, 2'd0, 32'h0);
        access("R8", 1'b1, 16'h01F6, 2'd0, 32'h10);
        cfg(8'h04, 32'h1);
        access("R8", 1'b0, 16'h01F5, 2'd0, 32'h0);

        repeat (6) @(negedge clk);
        chk("R13", "pending responses", 32'(rsp_q.size()), 32'h0);
        chk("R12", "pending drive transfers", 32'(drv_q.size()), 32'h0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule